// File: doc/BRIEF.md
# Coherent Wide-Value Register Slave

This block is a bus slave that carries values wider than its 32-bit data bus, each spread over consecutive word addresses, and keeps every multi-word access coherent. A read-only status input (33 bits by default, such as a free-running counter) takes the lowest status addresses. A read of its low word captures all of its upper bits into a shadow register. Later reads of its upper words return that shadow copy, so a value that moves between the two reads is never returned torn.

A control output (40 bits by default) takes the next addresses. With atomicity on, writes to its lower words go into staging registers. The output changes all at once when the highest word is written. A parameter for each value turns atomicity off. The status upper words then read the live input, and each control word write reaches the output at once.

Software reads a status value low word first and writes a control value high word last. The bus is a classic single-beat handshake. An access is acknowledged one cycle after the request for exactly one cycle, and it takes effect only on that acknowledged cycle.

Top module: `wide_reg_slave`

## Requirements
- R1: After reset, ack_o is 0, ctrl_o is 0, the status shadow is 0, and dat_o is 0 whenever ack_o is low.
- R2: A request (cyc_i and stb_i high) is acknowledged by ack_o high in the next cycle, for exactly one cycle. Reads, snapshot loads and writes take effect only while cyc_i, stb_i and ack_o are all high.
- R3: The status value sits at word addresses 0 and up, least significant word at address 0. A read of address 0 returns bits [31:0] of the live stat_i.
- R4: With STAT_ATOMIC=1, a read of address 0 loads stat_i[STAT_W-1:32] into the shadow. A read of address 1 returns the shadow, zero-extended. Example: address 0 is read while stat_i=0x1FFFFFFFF and returns 0xFFFFFFFF; stat_i then becomes 0x000000005; address 1 then returns 0x00000001.
- R5: With STAT_ATOMIC=1, an upper-word read returns the shadow from the last address-0 read, whatever stat_i holds now.
- R6: With STAT_ATOMIC=0, an upper-word read returns the live upper bits. In the R4 case it returns 0.
- R7: The control value sits at word addresses 2 and 3 (low word first). With CTRL_ATOMIC=1, a write to address 2 changes only staging. A write to address 3 sets ctrl_o to {dat_i[7:0], staged word} in one step.
- R8: Bits of the last control word above CTRL_W are ignored on write and read back as zero.
- R9: A read of a control address returns the committed ctrl_o word, not the staged data.
- R10: With CTRL_ATOMIC=0, every control word write updates its part of ctrl_o at once.
- R11: Addresses 4 and above read as zero, and writes to them change nothing.
- R12: With stb_i low, no acknowledge is given and ctrl_o does not change, even with cyc_i and we_i high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_i | input | 1 | Bus cycle active |
| stb_i | input | 1 | Transfer strobe |
| we_i | input | 1 | Write enable (1 = write) |
| adr_i | input | ADDR_W | Word address |
| dat_i | input | DATA_W | Write data |
| dat_o | output | DATA_W | Read data, valid while ack_o is high |
| ack_o | output | 1 | Single-cycle acknowledge |
| stat_i | input | STAT_W | Live wide status value |
| ctrl_o | output | CTRL_W | Committed wide control value |

## Verification
The bench goes after a counter that wraps between the low and high reads. A design whose upper word reads the live input returns 0 there in place of 1, halving the value. It checks that a stale shadow survives changes of the input, which catches a shadow that reloads on any access. It also checks that a lone low control write leaves ctrl_o alone, which an implementation writing straight through would break, and that junk above bit 39 never reaches ctrl_o or the read data. A second instance with both atomicity switches off confirms the non-atomic variants tear exactly as expected.

// File: rtl/wrs_pkg.sv
package wrs_pkg;
  function automatic int words_for(input int bits, input int dw);
    return (bits + dw - 1) / dw;
  endfunction
endpackage

// File: rtl/wrs_bus_if.sv
module wrs_bus_if (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cyc_i,
  input  logic stb_i,
  input  logic we_i,
  output logic ack_o,
  output logic rd_o,
  output logic wr_o
);
  logic ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ack_q <= 1'b0;
    else         ack_q <= cyc_i && stb_i && !ack_q;
  end

  logic acc;
  assign acc   = cyc_i && stb_i && ack_q;
  assign ack_o = ack_q;
  assign rd_o  = acc && !we_i;
  assign wr_o  = acc && we_i;
endmodule

// File: rtl/wrs_stat_port.sv
module wrs_stat_port #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 33,
  parameter bit ATOMIC = 1'b1,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] live_i,
  input  logic              rd_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int N     = wrs_pkg::words_for(STAT_W, DATA_W);
  localparam int PAD_W = N * DATA_W;
  localparam int UP_W  = PAD_W - DATA_W;

  logic [PAD_W-1:0] live_pad, view_pad;
  assign live_pad = PAD_W'(live_i);

  if (ATOMIC) begin : g_atomic
    logic [UP_W-1:0] snap_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   snap_q <= '0;
      else if (rd_i && idx_i == '0)  snap_q <= live_pad[PAD_W-1:DATA_W];
    end
    assign view_pad = {snap_q, live_pad[DATA_W-1:0]};
  end else begin : g_live
    logic unused_nat;
    assign unused_nat = clk_i ^ rst_ni ^ rd_i;
    assign view_pad   = live_pad;
  end

  assign rdata_o = view_pad[int'(idx_i)*DATA_W +: DATA_W];
endmodule

// File: rtl/wrs_ctrl_port.sv
module wrs_ctrl_port #(
  parameter int DATA_W = 32,
  parameter int CTRL_W = 40,
  parameter bit ATOMIC = 1'b1,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int N     = wrs_pkg::words_for(CTRL_W, DATA_W);
  localparam int PAD_W = N * DATA_W;
  localparam int LAST  = N - 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic [PAD_W-1:0]  ctrl_pad;
  assign ctrl_pad = PAD_W'(ctrl_q);

  if (ATOMIC) begin : g_atomic
    logic [LAST*DATA_W-1:0] stage_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= '0;
        ctrl_q  <= '0;
      end else if (wr_i) begin
        if (int'(idx_i) == LAST) ctrl_q <= CTRL_W'({wdata_i, stage_q});
        else                     stage_q[int'(idx_i)*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end else begin : g_direct
    logic [PAD_W-1:0] nxt_pad;
    always_comb begin
      nxt_pad = ctrl_pad;
      nxt_pad[int'(idx_i)*DATA_W +: DATA_W] = wdata_i;
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ctrl_q <= '0;
      else if (wr_i) ctrl_q <= CTRL_W'(nxt_pad);
    end
  end

  assign ctrl_o  = ctrl_q;
  assign rdata_o = ctrl_pad[int'(idx_i)*DATA_W +: DATA_W];
endmodule

// File: rtl/wide_reg_slave.sv
module wide_reg_slave #(
  parameter int DATA_W      = 32,
  parameter int STAT_W      = 33,
  parameter int CTRL_W      = 40,
  parameter bit STAT_ATOMIC = 1'b1,
  parameter bit CTRL_ATOMIC = 1'b1,
  parameter int ADDR_W      = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cyc_i,
  input  logic              stb_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] adr_i,
  input  logic [DATA_W-1:0] dat_i,
  output logic [DATA_W-1:0] dat_o,
  output logic              ack_o,
  input  logic [STAT_W-1:0] stat_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  localparam int STAT_N    = wrs_pkg::words_for(STAT_W, DATA_W);
  localparam int CTRL_N    = wrs_pkg::words_for(CTRL_W, DATA_W);
  localparam int CTRL_BASE = STAT_N;
  localparam int CTRL_END  = CTRL_BASE + CTRL_N;

  logic rd, wr, stat_hit, ctrl_hit;
  logic [ADDR_W-1:0] ctrl_idx;
  logic [DATA_W-1:0] stat_rd, ctrl_rd;

  assign stat_hit = adr_i < ADDR_W'(STAT_N);
  assign ctrl_hit = adr_i >= ADDR_W'(CTRL_BASE) && adr_i < ADDR_W'(CTRL_END);
  assign ctrl_idx = adr_i - ADDR_W'(CTRL_BASE);

  wrs_bus_if u_bus (
    .clk_i (clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i),
    .we_i  (we_i),  .ack_o (ack_o),  .rd_o (rd),    .wr_o (wr)
  );

  wrs_stat_port #(.DATA_W(DATA_W), .STAT_W(STAT_W), .ATOMIC(STAT_ATOMIC), .IDX_W(ADDR_W)) u_stat (
    .clk_i (clk_i), .rst_ni(rst_ni), .live_i(stat_i),
    .rd_i  (rd && stat_hit), .idx_i(adr_i), .rdata_o(stat_rd)
  );

  wrs_ctrl_port #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .ATOMIC(CTRL_ATOMIC), .IDX_W(ADDR_W)) u_ctrl (
    .clk_i (clk_i), .rst_ni(rst_ni), .wr_i(wr && ctrl_hit), .idx_i(ctrl_idx),
    .wdata_i(dat_i), .ctrl_o(ctrl_o), .rdata_o(ctrl_rd)
  );

  always_comb begin
    if (!ack_o)        dat_o = '0;
    else if (stat_hit) dat_o = stat_rd;
    else if (ctrl_hit) dat_o = ctrl_rd;
    else               dat_o = '0;
  end
endmodule

// File: rtl/wrs_checker.sv
module wrs_checker #(
  parameter int DATA_W = 32,
  parameter int STAT_W = 33,
  parameter int CTRL_W = 40,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cyc_i,
  input logic              stb_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] adr_i,
  input logic [DATA_W-1:0] dat_o,
  input logic              ack_o,
  input logic [STAT_W-1:0] stat_i,
  input logic [CTRL_W-1:0] ctrl_o
);
  localparam int MAP_END = wrs_pkg::words_for(STAT_W, DATA_W) + wrs_pkg::words_for(CTRL_W, DATA_W);

  a_r2_ack_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  a_r2_ack_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(cyc_i && stb_i));
  a_r1_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_o |-> dat_o == '0);
  a_r3_low_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !we_i && adr_i == '0) |-> dat_o == stat_i[DATA_W-1:0]);
  a_r7_ctrl_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cyc_i && stb_i && we_i && ack_o) |=> $stable(ctrl_o));
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && adr_i >= ADDR_W'(MAP_END)) |-> dat_o == '0);
endmodule

bind wide_reg_slave wrs_checker #(
  .DATA_W(DATA_W), .STAT_W(STAT_W), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
  .adr_i(adr_i), .dat_o(dat_o), .ack_o(ack_o), .stat_i(stat_i), .ctrl_o(ctrl_o)
);

// File: tb/wide_reg_slave_tb_top.sv
`timescale 1ns/1ps
module wide_reg_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [3:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [32:0] stat = '0;
  logic [31:0] dat_a, dat_n;
  logic        ack_a, ack_n;
  logic [39:0] ctrl_a, ctrl_n;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  wide_reg_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .dat_o(dat_a), .ack_o(ack_a), .stat_i(stat), .ctrl_o(ctrl_a));

  wide_reg_slave #(.STAT_ATOMIC(1'b0), .CTRL_ATOMIC(1'b0)) dut_na_i (
    .clk_i(clk), .rst_ni(rst_n), .cyc_i(cyc), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_i(wdat), .dat_o(dat_n), .ack_o(ack_n), .stat_i(stat), .ctrl_o(ctrl_n));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus access; returns read data of both instances
  task automatic acc(input logic w, input logic [3:0] a, input logic [31:0] d,
                     output logic [31:0] ra, output logic [31:0] rn);
    @(negedge clk);
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = d;
    @(negedge clk);
    chk("R2 ack", {62'd0, ack_a, ack_n}, 64'd3);
    ra = dat_a; rn = dat_n;
    @(negedge clk);
    chk("R2 ack drop", {62'd0, ack_a, ack_n}, 64'd0);
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ack", {62'd0, ack_a, ack_n}, 64'd0);
    chk("R1 ctrl", {24'd0, ctrl_a}, 64'd0);
    chk("R1 dat", {dat_a, dat_n}, 64'd0);
  endtask

  task automatic t_shadow_reset();
    logic [31:0] ra, rn;
    stat = 33'h1_0000_0000;
    acc(1'b0, 4'd1, '0, ra, rn);
    chk("R1 shadow", {32'd0, ra}, 64'd0);
  endtask

  task automatic t_wrap();
    logic [31:0] ra, rn;
    stat = 33'h1_FFFF_FFFF;
    acc(1'b0, 4'd0, '0, ra, rn);
    chk("R3 low", {32'd0, ra}, 64'hFFFF_FFFF);
    chk("R3 low na", {32'd0, rn}, 64'hFFFF_FFFF);
    stat = 33'h0_0000_0005;
    acc(1'b0, 4'd1, '0, ra, rn);
    chk("R4 upper", {32'd0, ra}, 64'd1);
    chk("R6 upper live", {32'd0, rn}, 64'd0);
  endtask

  task automatic t_stale();
    logic [31:0] ra, rn;
    stat = 33'h0_1234_5678;
    acc(1'b0, 4'd0, '0, ra, rn);
    chk("R3 low2", {32'd0, ra}, 64'h1234_5678);
    stat = 33'h1_0000_0000;
    repeat (3) @(negedge clk);
    acc(1'b0, 4'd1, '0, ra, rn);
    chk("R5 stale shadow", {32'd0, ra}, 64'd0);
    chk("R6 live", {32'd0, rn}, 64'd1);
    acc(1'b0, 4'd1, '0, ra, rn);
    chk("R5 no reload", {32'd0, ra}, 64'd0);
  endtask

  task automatic t_ctrl();
    logic [31:0] ra, rn;
    acc(1'b1, 4'd2, 32'hA5A5_1234, ra, rn);
    chk("R7 staged", {24'd0, ctrl_a}, 64'd0);
    chk("R10 direct low", {24'd0, ctrl_n}, 64'h00_A5A5_1234);
    acc(1'b0, 4'd2, '0, ra, rn);
    chk("R9 readback staged", {32'd0, ra}, 64'd0);
    acc(1'b1, 4'd3, 32'hFFFF_FF3C, ra, rn);
    chk("R7 commit", {24'd0, ctrl_a}, 64'h3C_A5A5_1234);
    chk("R10 direct high", {24'd0, ctrl_n}, 64'h3C_A5A5_1234);
    acc(1'b0, 4'd3, '0, ra, rn);
    chk("R8 high reads zero", {32'd0, ra}, 64'h3C);
    acc(1'b0, 4'd2, '0, ra, rn);
    chk("R9 readback low", {32'd0, ra}, 64'hA5A5_1234);
    acc(1'b1, 4'd3, 32'hFFFF_FF00, ra, rn);
    chk("R8 ignore junk", {24'd0, ctrl_a}, 64'h00_A5A5_1234);
  endtask

  task automatic t_unmapped();
    logic [31:0] ra, rn;
    acc(1'b1, 4'd4, 32'hDEAD_BEEF, ra, rn);
    chk("R11 write ignored", {24'd0, ctrl_a}, 64'h00_A5A5_1234);
    acc(1'b0, 4'd4, '0, ra, rn);
    chk("R11 read zero", {ra, rn}, 64'd0);
    acc(1'b0, 4'd15, '0, ra, rn);
    chk("R11 read top", {ra, rn}, 64'd0);
  endtask

  task automatic t_no_strobe();
    @(negedge clk);
    cyc = 1'b1; stb = 1'b0; we = 1'b1; adr = 4'd3; wdat = 32'h0000_0077;
    repeat (4) begin
      @(negedge clk);
      chk("R12 no ack", {62'd0, ack_a, ack_n}, 64'd0);
    end
    chk("R12 ctrl held", {24'd0, ctrl_a}, 64'h00_A5A5_1234);
    cyc = 1'b0; we = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_shadow_reset();
    t_wrap();
    t_stale();
    t_ctrl();
    t_unmapped();
    t_no_strobe();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule